// File: doc/BRIEF.md
# Three-Requester Recency Arbiter

This block shares one resource among three requesters and grants it to at most one of them in each cycle. Requests arrive on a three-bit vector and the acknowledge vector answers in the same cycle, with no register between them. A requester keeps its request high for as long as it wants service. It drops the request once it has been served or when it no longer needs the resource.

The arbiter keeps two pieces of registered state. A history bit per requester records who won on the previous cycle. A full recency ordering records which requester was served longest ago. The previous winner is demoted: it wins only when it is the sole requester, and its pending request never holds back anyone else. Among the remaining eligible requesters, the least recently served one wins. Demoting only the previous winner can let two requesters take turns forever while the third waits. The ordering prevents this, so every requester that keeps asking is served within a few cycles.

Bit 0 of the request and acknowledge vectors is the first requester, bit 1 the second and bit 2 the third. Reset is synchronous and active high.

Top module: `recency_arbiter`

## Requirements
- R1: In every cycle at most one bit of `ack` is high.
- R2: In any cycle in which at least one bit of `req` is high, exactly one bit of `ack` is high in that same cycle. This includes the first cycle after reset is released.
- R3: `ack[i]` is high only in a cycle in which `req[i]` is high.
- R4: After reset the ordering ranks bit 0 first, then bit 1, then bit 2. With all three requesting, the acknowledges in the first three cycles are 3'b001, 3'b010 and 3'b100.
- R5: A requester that was acknowledged in the previous cycle is acknowledged again only if no other bit of `req` is high.
- R6: A demoted requester does not block a lower-ranked one. After a lone grant to bit 0 (3'b001), a request of 3'b101 yields an acknowledge of 3'b100.
- R7: Each grant moves the winner to the most-recent end of the ordering. Among the eligible requests, the one granted least recently wins.
- R8: A requester that holds its request high is acknowledged within three consecutive cycles. It sees at most two cycles of request without acknowledge.
- R9: A cycle with `req` equal to 3'b000 gives `ack` equal to 3'b000 and leaves the ordering unchanged. Demotion no longer applies after such a cycle.
- R10: Reset clears all history bits and restores the initial ordering, even in the middle of operation.
- R11: Requesters 0 and 1 alternating or requesting together never starve requester 2 when requester 2 requests continuously. With all three requesting, the grants rotate 0, 1, 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 3 | Request lines, bit 0 is the first requester |
| ack | output | 3 | Same-cycle acknowledge lines, one-hot or zero |

## Verification
The assertions assume that `req` holds known values on every rising edge outside reset. They also assume that reset is held for at least one rising edge, so that the history bits, the ordering and the checker's own wait counters start from cleared values. The waiting bound counts only unbroken runs of a high request, so a requester that drops and re-raises its line starts a fresh window. The bench changes `req` only on falling edges, keeps it at zero while reset is high and releases reset between edges. Every pattern it drives, including the pseudo-random stretch, therefore stays within these assumptions.

// File: rtl/recency_arb_pkg.sv
package recency_arb_pkg;
  localparam int unsigned ARB_N = 3;

  typedef logic [ARB_N-1:0] reqVec_t;
  // beatMat[i][j] == 1 : requester i ranks ahead of requester j
  typedef logic [ARB_N-1:0][ARB_N-1:0] beatMat_t;

  typedef struct packed {
    logic    commit;   // a grant happened this cycle
    reqVec_t winner;   // one-hot winner, zero when idle
  } arbStrobe_t;

  function automatic beatMat_t initialRanking();
    beatMat_t m;
    m = '0;
    for (int i = 0; i < ARB_N; i++)
      for (int j = 0; j < ARB_N; j++)
        m[i][j] = (i < j);
    return m;
  endfunction
endpackage

// File: rtl/recency_state.sv
module recency_state
  import recency_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  arbStrobe_t strobe,
  output beatMat_t   beatMat,
  output reqVec_t    histBits
);
  beatMat_t beatNext;

  always_comb begin
    beatNext = beatMat;
    if (strobe.commit) begin
      for (int i = 0; i < ARB_N; i++) begin
        for (int j = 0; j < ARB_N; j++) begin
          if (i != j) begin
            if (strobe.winner[i])      beatNext[i][j] = 1'b0;  // winner falls behind everyone
            else if (strobe.winner[j]) beatNext[i][j] = 1'b1;  // everyone moves ahead of winner
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beatMat  <= initialRanking();
      histBits <= '0;
    end else begin
      beatMat  <= beatNext;
      histBits <= strobe.winner;
    end
  end
endmodule

// File: rtl/recency_grant_ctrl.sv
module recency_grant_ctrl
  import recency_arb_pkg::*;
(
  input  reqVec_t    req,
  input  beatMat_t   beatMat,
  input  reqVec_t    histBits,
  output reqVec_t    ack,
  output arbStrobe_t strobe
);
  reqVec_t eligible;

  for (genvar i = 0; i < ARB_N; i++) begin : g_elig
    localparam reqVec_t SelfBit = reqVec_t'(1) << i;
    logic othersReq;
    assign othersReq   = |(req & ~SelfBit);
    // demotion: last winner only competes when alone
    assign eligible[i] = req[i] & (~histBits[i] | ~othersReq);
  end

  for (genvar i = 0; i < ARB_N; i++) begin : g_pick
    reqVec_t beatenBy;
    always_comb begin
      beatenBy = '0;
      for (int j = 0; j < ARB_N; j++)
        if (j != i) beatenBy[j] = eligible[j] & beatMat[j][i];
    end
    assign ack[i] = eligible[i] & ~(|beatenBy);
  end

  assign strobe.commit = |ack;
  assign strobe.winner = ack;
endmodule

// File: rtl/recency_arbiter.sv
module recency_arbiter (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] req,
  output logic [2:0] ack
);
  import recency_arb_pkg::*;

  arbStrobe_t strobe;
  beatMat_t   beatMat;
  reqVec_t    histBits;

  recency_grant_ctrl u_ctrl (
    .req     (req),
    .beatMat (beatMat),
    .histBits(histBits),
    .ack     (ack),
    .strobe  (strobe)
  );

  recency_state u_state (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .beatMat (beatMat),
    .histBits(histBits)
  );
endmodule

// File: rtl/recency_arbiter_checker.sv
module recency_arbiter_checker
  import recency_arb_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input reqVec_t  req,
  input reqVec_t  ack,
  input beatMat_t beatMat
);
  localparam int unsigned MaxWait = ARB_N - 1;
  localparam int unsigned CntW    = $clog2(MaxWait + 2);

  reqVec_t prevAck;
  logic    rankConsistent;

  always_ff @(posedge clk) begin
    if (rst) prevAck <= '0;
    else     prevAck <= ack;
  end

  always_comb begin
    rankConsistent = 1'b1;
    for (int i = 0; i < ARB_N; i++)
      for (int j = 0; j < ARB_N; j++)
        if (i != j && beatMat[i][j] == beatMat[j][i]) rankConsistent = 1'b0;
  end

  p_mutex_r1: assert property (@(posedge clk) disable iff (rst) $onehot0(ack));
  p_serve_r2: assert property (@(posedge clk) disable iff (rst) (|req) |-> (|ack));
  p_no_waste_r3: assert property (@(posedge clk) disable iff (rst) ((ack & ~req) == '0));
  p_demote_r5: assert property (@(posedge clk) disable iff (rst)
    ((prevAck & ack) != '0) |-> ($countones(req) == 1));
  p_rank_total_r7: assert property (@(posedge clk) disable iff (rst) rankConsistent);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst) (req == '0) |-> (ack == '0));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst) (req == '0) |=> $stable(beatMat));

  for (genvar i = 0; i < ARB_N; i++) begin : g_wait
    logic [CntW-1:0] waitCnt;
    always_ff @(posedge clk) begin
      if (rst)                      waitCnt <= '0;
      else if (req[i] && !ack[i]) begin
        if (waitCnt != '1)          waitCnt <= waitCnt + 1'b1;
      end else                      waitCnt <= '0;
    end
    p_bounded_wait_r8: assert property (@(posedge clk) disable iff (rst) waitCnt <= CntW'(MaxWait));
  end
endmodule

bind recency_arbiter recency_arbiter_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .req    (req),
  .ack    (ack),
  .beatMat(beatMat)
);

// File: tb/recency_arbiter_test.sv
`timescale 1ns/1ps
module recency_arbiter_test;
  localparam time HalfPeriod = 10ns;   // 50 MHz
  localparam int  MaxWaitTb  = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req = 3'b000;
  logic [2:0] ack;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [2:0] reqV;
    logic [2:0] expAck;
    string      tag;
  } sbItem_t;
  sbItem_t sbQ[$];

  int ordQ[3];         // oldest first
  int waitTb[3];

  recency_arbiter uut (.clk(clk), .rst(rst), .req(req), .ack(ack));

  always #(HalfPeriod) clk = ~clk;

  task automatic modelReset();
    ordQ[0] = 0; ordQ[1] = 1; ordQ[2] = 2;
  endtask

  function automatic logic [2:0] modelPick(logic [2:0] r);
    for (int k = 0; k < 3; k++)
      if (r[ordQ[k]]) return 3'b001 << ordQ[k];
    return 3'b000;
  endfunction

  task automatic modelCommit(logic [2:0] a);
    int w;
    int pos;
    if (a == 3'b000) return;
    w = (a == 3'b001) ? 0 : (a == 3'b010) ? 1 : 2;
    pos = 0;
    for (int k = 0; k < 3; k++) if (ordQ[k] == w) pos = k;
    for (int k = pos; k < 2; k++) ordQ[k] = ordQ[k+1];
    ordQ[2] = w;
  endtask

  task automatic check(bit ok, string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // driver: apply a request for one cycle and queue the expected acknowledge
  task automatic drive(logic [2:0] r, string tag);
    sbItem_t it;
    @(negedge clk);
    req = r;
    it.reqV   = r;
    it.expAck = modelPick(r);
    it.tag    = tag;
    sbQ.push_back(it);
    modelCommit(it.expAck);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    req = 3'b000;
    @(posedge clk);
    #(HalfPeriod / 2);
    rst = 1'b0;
    modelReset();
  endtask

  // monitor: compare against the scoreboard away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #(HalfPeriod / 2);
      if (rst) begin
        for (int k = 0; k < 3; k++) waitTb[k] = 0;
      end else if (sbQ.size() > 0) begin
        sbItem_t it;
        it = sbQ.pop_front();
        check(ack === it.expAck, it.tag, ack, it.expAck);
        check($countones(ack) <= 1, "R1 one-hot acknowledge", ack, it.expAck);
        check(!(it.reqV != 0 && ack == 0), "R2 request served same cycle", ack, it.expAck);
        check((ack & ~it.reqV) == 3'b000, "R3 acknowledge without request", ack, it.reqV);
        for (int k = 0; k < 3; k++) begin
          if (it.reqV[k] && !ack[k]) waitTb[k]++;
          else                       waitTb[k] = 0;
          check(waitTb[k] <= MaxWaitTb, "R8 bounded wait exceeded", ack, it.reqV);
        end
      end
    end
  end

  initial begin
    #(HalfPeriod * 2 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    modelReset();
    repeat (3) @(negedge clk);
    doReset();

    // R10 / R9: reset state with no request
    drive(3'b000, "R10 reset state idle ack");
    // R4: initial ranking 0,1,2 ; R11 rotation
    drive(3'b111, "R4 first grant to bit 0");
    drive(3'b111, "R4 second grant to bit 1");
    drive(3'b111, "R4 third grant to bit 2");
    drive(3'b111, "R11 rotation wraps to bit 0");
    // R5: previous winner alone is granted, with others it is demoted
    drive(3'b001, "R5 lone previous winner granted");
    drive(3'b011, "R5 previous winner demoted");
    // R9: idle cycles keep ordering (order now 2,0,1)
    drive(3'b000, "R9 idle no ack");
    drive(3'b000, "R9 idle no ack");
    drive(3'b111, "R9 ordering kept over idle");
    drive(3'b011, "R7 least recent wins");

    // R6: demoted bit 0 does not block bit 2
    doReset();
    drive(3'b001, "R2 first cycle after reset");
    drive(3'b101, "R6 demoted does not block lower");
    drive(3'b011, "R7 least recent of 0 and 1");

    // R11: bit 2 requests continuously while 0 and 1 alternate
    doReset();
    for (int n = 0; n < 30; n++)
      drive((n % 2 == 0) ? 3'b101 : 3'b110, "R11 alternating with steady bit 2");
    for (int n = 0; n < 12; n++)
      drive(3'b111, "R11 all three continuous");

    // R7 / R8: pseudo-random mix
    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[2:0] | (lfsr[5:3] & lfsr[8:6]), "R7 random pattern");
    end

    // R10: reset in mid-operation restores initial ranking
    drive(3'b111, "R7 before mid reset");
    doReset();
    drive(3'b111, "R10 ranking restored after reset");
    drive(3'b110, "R10 history cleared after reset");

    @(negedge clk);
    req = 3'b000;
    wait (sbQ.size() == 0);
    @(negedge clk);
    #(HalfPeriod);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule